// File: doc/BRIEF.md
# Direct-Mapped Cache Tag Store with Hit Compare

The block keeps one tag record per cache line of a direct-mapped cache. A record is a tag value plus two status flags, valid and dirty. The line index selects one record. Records are written on the rising clock edge. The stored record is read combinationally, so a hit or miss is known in the same cycle that the index and tag are presented.

Two active-low strobes choose what each cycle does:

| `wr_n` | `oe_n` | Cycle type |
|---|---|---|
| 1 | 1 | Compare. The presented tag is checked against the stored tag and qualified by the valid flag. |
| 1 | 0 | Read. The stored tag is driven out. |
| 0 | 1 | Write. The record is updated at the clock edge. |
| 0 | 0 | Illegal. It is handled safely as a read. |

The stored dirty flag of the addressed line is always visible. The cache controller uses it to decide whether a victim line needs a write-back.

The active-low clear input invalidates every line at one clock edge. It also forces the outputs to a quiet state and then starts a recovery window. During that window write requests are refused. A shared bidirectional tag bus is modelled as three separate signals: tag input, tag output, and an output-drive flag. When the drive flag is low, it stands in for high impedance.

Top module: `cache_tag_store`

## Requirements
- R1: After synchronous reset every line is invalid and not dirty: a compare on any line gives `match` = 0 and `dirty_out` = 0, and `busy` = 0.
- R2: A write (`clr_n`=1, `wr_n`=0, `oe_n`=1, `busy`=0) stores `tag_in`, `valid_in` and `dirty_in` into the line at `idx` on the rising clock edge.
- R3: In compare mode (`wr_n`=1, `oe_n`=1, `clr_n`=1), `match` is 1 in the same cycle exactly when the stored valid flag is 1 and the stored tag equals `tag_in`.
- R4: A line whose stored valid flag is 0 never matches, even when its stored tag equals `tag_in`.
- R5: In read mode (`oe_n`=0, `wr_n`=1, `clr_n`=1), `tag_oe` = 1, `match` = 0, and `tag_out` carries the stored tag. `tag_out` also carries the stored tag in compare mode.
- R6: Outside writes and clears, `dirty_out` shows the stored dirty flag of the line at `idx`.
- R7: During an accepted write, the following hold in the same cycle:
  - `match` = 0 and `tag_oe` = 0;
  - `dirty_out` equals `dirty_in`;
  - `tag_out` equals `tag_in` (write-through).
- R8: `tag_oe` is 1 only when `oe_n` = 0 and `clr_n` = 1. A 0 on `tag_oe` stands for a released, high-impedance tag bus.
- R9: `wr_n`=0 together with `oe_n`=0 stores nothing and behaves as a read: `tag_oe` = 1 and `match` = 0.
- R10: A rising edge with `clr_n`=0 clears the valid and dirty flags of every line. While `clr_n` is 0, `match`, `dirty_out`, `tag_oe` and `tag_out` are all 0, and writes are ignored.
- R11: `busy` rises at the edge that samples `clr_n`=0. It stays high for `RECOVER_CYC` rising edges after `clr_n` returns to 1. A write request while `busy` is high stores nothing and the cycle behaves as a compare. The write at the next edge after that is accepted.
- R12: A write changes only the addressed line; records at other indices keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Active-low bulk invalidate of all status flags |
| idx | input | INDEX_W | Line index |
| tag_in | input | TAG_W | Tag to compare or to write |
| valid_in | input | 1 | Valid flag to write |
| dirty_in | input | 1 | Dirty flag to write |
| wr_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low tag output enable |
| tag_out | output | TAG_W | Stored tag, or `tag_in` during a write, 0 during clear |
| tag_oe | output | 1 | Tag bus drive flag (0 = high impedance) |
| match | output | 1 | Hit: valid line with equal tag, compare mode only |
| dirty_out | output | 1 | Dirty flag of the addressed line |
| busy | output | 1 | Recovery window after a clear; writes refused |

## Verification
A corrupted valid flag shows up as a wrong `match` on the first compare of that line. A corrupted dirty flag shows up on `dirty_out` as soon as the line is addressed. Both appear combinationally, in the very cycle the index is presented, so every stored record can be observed one cycle after it was written.

A recovery counter that is off by one changes how many edges `busy` stays high. It also changes whether a write held through the window lands, which a later compare of that line reveals. A clear that misses some flags leaves a stale hit that is visible on the first compare after the clear.

// File: rtl/ctag_pkg.sv
package ctag_pkg;

    // Cycle type decoded from the strobes
    typedef enum logic [2:0] {
        OP_CMP,   // compare presented tag against stored record
        OP_RD,    // drive stored tag out
        OP_WR,    // update record at the clock edge
        OP_BAD,   // both strobes low: handled as a read, nothing stored
        OP_CLR    // bulk invalidate in progress
    } op_e;

    typedef struct packed {
        logic valid;
        logic dirty;
    } stat_t;

    // Priority: clear, illegal pair, read, accepted write, compare.
    // A refused write (busy) falls through to compare.
    function automatic op_e decode_op(input logic clr_n, input logic wr_n,
                                      input logic oe_n, input logic busy);
        if (!clr_n)           return OP_CLR;
        if (!wr_n && !oe_n)   return OP_BAD;
        if (!oe_n)            return OP_RD;
        if (!wr_n && !busy)   return OP_WR;
        return OP_CMP;
    endfunction

endpackage

// File: rtl/ctag_status_array.sv
module ctag_status_array
    import ctag_pkg::*;
#(
    parameter int INDEX_W = 10,
    localparam int DEPTH  = 1 << INDEX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               we,
    input  logic [INDEX_W-1:0] idx,
    input  stat_t              wstat,
    output stat_t              rstat
);

    // Flags kept in flops so the whole array empties in one edge
    logic [DEPTH-1:0] valid_q;
    logic [DEPTH-1:0] dirty_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (we) begin
            valid_q[idx] <= wstat.valid;
            dirty_q[idx] <= wstat.dirty;
        end
    end

    always_comb begin
        rstat.valid = valid_q[idx];
        rstat.dirty = dirty_q[idx];
    end

endmodule

// File: rtl/ctag_tag_array.sv
module ctag_tag_array #(
    parameter int INDEX_W = 10,
    parameter int TAG_W   = 12,
    localparam int DEPTH  = 1 << INDEX_W
) (
    input  logic               clk,
    input  logic               we,
    input  logic [INDEX_W-1:0] idx,
    input  logic [TAG_W-1:0]   wtag,
    output logic [TAG_W-1:0]   rtag
);

    // Tag storage needs no reset: the valid flag guards its use
    logic [TAG_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wtag;
        end
    end

    assign rtag = mem[idx];

endmodule

// File: rtl/ctag_recovery.sv
module ctag_recovery #(
    parameter int RECOVER_CYC = 4,
    localparam int CNT_W      = $clog2(RECOVER_CYC + 2)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic busy
);

    logic [CNT_W-1:0] cnt_q;

    // Held at full count while clearing, then counts down per edge
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= CNT_W'(RECOVER_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/cache_tag_store.sv
module cache_tag_store
    import ctag_pkg::*;
#(
    parameter int INDEX_W     = 10,
    parameter int TAG_W       = 12,
    parameter int RECOVER_CYC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_n,
    input  logic [INDEX_W-1:0] idx,
    input  logic [TAG_W-1:0]   tag_in,
    input  logic               valid_in,
    input  logic               dirty_in,
    input  logic               wr_n,
    input  logic               oe_n,
    output logic [TAG_W-1:0]   tag_out,
    output logic               tag_oe,
    output logic               match,
    output logic               dirty_out,
    output logic               busy
);

    op_e              op;
    logic             we;
    logic             clr;
    stat_t            wstat;
    stat_t            rstat;
    logic [TAG_W-1:0] rtag;
    logic             tag_eq;

    assign clr   = !clr_n;
    assign op    = decode_op(clr_n, wr_n, oe_n, busy);
    assign we    = (op == OP_WR);
    assign wstat = '{valid: valid_in, dirty: dirty_in};

    ctag_status_array #(.INDEX_W(INDEX_W)) u_stat (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .we    (we),
        .idx   (idx),
        .wstat (wstat),
        .rstat (rstat)
    );

    ctag_tag_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
        .clk  (clk),
        .we   (we),
        .idx  (idx),
        .wtag (tag_in),
        .rtag (rtag)
    );

    generate
        if (RECOVER_CYC > 0) begin : g_recover
            ctag_recovery #(.RECOVER_CYC(RECOVER_CYC)) u_rec (
                .clk  (clk),
                .rst  (rst),
                .clr  (clr),
                .busy (busy)
            );
        end else begin : g_no_recover
            assign busy = 1'b0;
        end
    endgenerate

    assign tag_eq = (rtag == tag_in);

    always_comb begin
        tag_out   = rtag;
        tag_oe    = 1'b0;
        match     = 1'b0;
        dirty_out = rstat.dirty;
        unique case (op)
            OP_CLR: begin
                tag_out   = '0;
                dirty_out = 1'b0;
            end
            OP_WR: begin
                tag_out   = tag_in;
                dirty_out = dirty_in;
            end
            OP_RD, OP_BAD: begin
                tag_oe = 1'b1;
            end
            OP_CMP: begin
                match = rstat.valid && tag_eq;
            end
            default: begin
                tag_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cache_tag_store_chk.sv
module cache_tag_store_chk #(
    parameter int INDEX_W     = 10,
    parameter int TAG_W       = 12,
    parameter int RECOVER_CYC = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               clr_n,
    input logic [INDEX_W-1:0] idx,
    input logic [TAG_W-1:0]   tag_in,
    input logic               valid_in,
    input logic               dirty_in,
    input logic               wr_n,
    input logic               oe_n,
    input logic [TAG_W-1:0]   tag_out,
    input logic               tag_oe,
    input logic               match,
    input logic               dirty_out,
    input logic               busy
);

    // R3
    match_only_in_compare_chk: assert property (@(posedge clk) disable iff (rst)
        match |-> (clr_n && wr_n && oe_n));

    // R10
    clear_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (!match && !dirty_out && !tag_oe && tag_out == '0));

    // R10
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!clr_n) && clr_n && wr_n && oe_n) |-> (!match && !dirty_out));

    // R8
    drive_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        tag_oe |-> (!oe_n && clr_n));

    // R7
    write_through_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !wr_n && oe_n && !busy) |->
            (!match && !tag_oe && dirty_out == dirty_in && tag_out == tag_in));

    // R9
    illegal_pair_read_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !wr_n && !oe_n) |-> (!match && tag_oe));

    // R2
    write_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(clr_n && !wr_n && oe_n && !busy) &&
         clr_n && wr_n && oe_n && idx == $past(idx) && tag_in == $past(tag_in))
            |-> (match == $past(valid_in)));

    generate
        if (RECOVER_CYC > 0) begin : g_busy_chk
            // R11
            busy_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
                !clr_n |=> busy);
        end
    endgenerate

endmodule

bind cache_tag_store cache_tag_store_chk #(
    .INDEX_W     (INDEX_W),
    .TAG_W       (TAG_W),
    .RECOVER_CYC (RECOVER_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr_n     (clr_n),
    .idx       (idx),
    .tag_in    (tag_in),
    .valid_in  (valid_in),
    .dirty_in  (dirty_in),
    .wr_n      (wr_n),
    .oe_n      (oe_n),
    .tag_out   (tag_out),
    .tag_oe    (tag_oe),
    .match     (match),
    .dirty_out (dirty_out),
    .busy      (busy)
);

// File: tb/cache_tag_store_tb.sv
module cache_tag_store_tb;

    localparam int INDEX_W     = 10;
    localparam int TAG_W       = 12;
    localparam int RECOVER_CYC = 4;

    typedef struct packed {
        logic             wr_n;
        logic             oe_n;
        logic [INDEX_W-1:0] idx;
        logic [TAG_W-1:0] tag;
        logic             v;
        logic             d;
        logic             e_match;
        logic             e_dirty;
        logic             e_oe;
        logic [TAG_W-1:0] e_tag;
    } vec_t;

    // fields: wr_n, oe_n, idx, tag, valid_in, dirty_in | match, dirty_out, tag_oe, tag_out
    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 10'd5, 12'hABC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 12'hABC}, // R7 write line 5
        '{1'b0, 1'b1, 10'd9, 12'h123, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 12'h123}, // R7 write line 9
        '{1'b0, 1'b1, 10'd7, 12'h555, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12'h555}, // R7 write invalid line 7
        '{1'b1, 1'b1, 10'd5, 12'hABC, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 12'hABC}, // R2 R3 hit
        '{1'b1, 1'b1, 10'd5, 12'hABD, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'hABC}, // R3 tag differs
        '{1'b1, 1'b1, 10'd9, 12'h123, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 12'h123}, // R6 hit, dirty
        '{1'b1, 1'b1, 10'd7, 12'h555, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h555}, // R4 invalid no hit
        '{1'b1, 1'b0, 10'd9, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h123}, // R5 R8 read
        '{1'b0, 1'b0, 10'd5, 12'hFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 12'hABC}, // R9 illegal pair
        '{1'b1, 1'b1, 10'd5, 12'hABC, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 12'hABC}, // R9 nothing stored
        '{1'b1, 1'b1, 10'd9, 12'h123, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 12'h123}, // R12 line 9 intact
        '{1'b0, 1'b1, 10'd9, 12'h123, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 12'h123}, // R2 rewrite clean
        '{1'b1, 1'b1, 10'd9, 12'h123, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 12'h123}  // R6 now clean
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               clr_n = 1'b1;
    logic [INDEX_W-1:0] idx = '0;
    logic [TAG_W-1:0]   tag_in = '0;
    logic               valid_in = 1'b0;
    logic               dirty_in = 1'b0;
    logic               wr_n = 1'b1;
    logic               oe_n = 1'b1;
    logic [TAG_W-1:0]   tag_out;
    logic               tag_oe;
    logic               match;
    logic               dirty_out;
    logic               busy;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cache_tag_store #(
        .INDEX_W(INDEX_W), .TAG_W(TAG_W), .RECOVER_CYC(RECOVER_CYC)
    ) u_dut (
        .clk(clk), .rst(rst), .clr_n(clr_n), .idx(idx), .tag_in(tag_in),
        .valid_in(valid_in), .dirty_in(dirty_in), .wr_n(wr_n), .oe_n(oe_n),
        .tag_out(tag_out), .tag_oe(tag_oe), .match(match),
        .dirty_out(dirty_out), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic o, input int i, input logic [TAG_W-1:0] t,
                         input logic v, input logic d);
        wr_n = w; oe_n = o; idx = INDEX_W'(i); tag_in = t; valid_in = v; dirty_in = d;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int edges;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset leaves every line empty
        drive(1'b1, 1'b1, 0, 12'h000, 1'b0, 1'b0);
        #2;
        chk("R1 match/dirty/busy after reset", {match, dirty_out, busy}, 3'b000);
        drive(1'b1, 1'b1, 1023, 12'h000, 1'b0, 1'b0);
        #2;
        chk("R1 last line empty", {match, dirty_out}, 2'b00);

        // Vector table
        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            drive(VECS[k].wr_n, VECS[k].oe_n, int'(VECS[k].idx), VECS[k].tag,
                  VECS[k].v, VECS[k].d);
            #2;
            chk($sformatf("R2-vector %0d {match,dirty,oe,tag}", k),
                {match, dirty_out, tag_oe, tag_out},
                {VECS[k].e_match, VECS[k].e_dirty, VECS[k].e_oe, VECS[k].e_tag});
        end

        // R10: clear with the read enable asserted and a write requested
        @(negedge clk);
        clr_n = 1'b0;
        drive(1'b1, 1'b0, 5, 12'hABC, 1'b1, 1'b1);
        #2;
        chk("R10 outputs quiet during clear", {match, dirty_out, tag_oe}, 3'b000);
        chk("R8 no drive during clear", tag_oe, 1'b0);
        chk("R10 tag_out zero during clear", tag_out, 12'h000);
        drive(1'b0, 1'b1, 3, 12'h0F0, 1'b1, 1'b1);

        @(negedge clk);
        clr_n = 1'b1;
        drive(1'b1, 1'b1, 5, 12'hABC, 1'b0, 1'b0);
        #2;
        chk("R10 line 5 invalid after clear", match, 1'b0);
        chk("R11 busy after clear", busy, 1'b1);
        drive(1'b1, 1'b1, 9, 12'h123, 1'b0, 1'b0);
        #1;
        chk("R10 line 9 no hit, not dirty", {match, dirty_out}, 2'b00);

        // R11: hold a write request through the recovery window
        drive(1'b0, 1'b1, 3, 12'h0F0, 1'b1, 1'b1);
        #1;
        chk("R11 refused write acts as compare", {match, tag_oe}, 2'b00);
        edges = 0;
        while (busy && edges < 100) begin
            @(posedge clk);
            @(negedge clk);
            edges++;
        end
        chk("R11 busy edge count", edges, RECOVER_CYC);
        drive(1'b1, 1'b1, 3, 12'h0F0, 1'b0, 1'b0);
        #2;
        chk("R11 writes in window ignored", {match, dirty_out}, 2'b00);

        drive(1'b0, 1'b1, 3, 12'h0F0, 1'b1, 1'b1);
        @(negedge clk);
        drive(1'b1, 1'b1, 3, 12'h0F0, 1'b0, 1'b0);
        #2;
        chk("R11 write after window accepted", {match, dirty_out}, 2'b11);
        drive(1'b1, 1'b1, 4, 12'h0F0, 1'b0, 1'b0);
        #2;
        chk("R12 neighbour line untouched", match, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule